// File: doc/BRIEF.md
# Flash Sector Write-Protect Register

This block holds one write-protect bit for each low address space sector of an embedded flash. A bit at 1 shields its sector from program and erase; a bit at 0 lets the sector take program and erase pulses, provided the matching primary lock bit is also 0. The block combines the two lock vectors into a registered per-sector permission vector for the flash controller. It also holds an erase-target select register and passes an erase request on only for sectors that are both selected and permitted.

On every reset the lock bits are loaded from a nonvolatile configuration image, so an erased, all-ones image leaves every sector locked. Software updates the lock bits over a 32-bit single-cycle register port. A lock write takes effect only if three conditions hold: the protect-enable bit is set, no interlocked operation is pending, and no high-voltage operation is suspended. The parameter `NUM_IMPL` sets how many sectors exist. Lock bits for missing sectors always read 1 and cannot be written.

Top module: `flash_wp_reg`

## Requirements
- R1: A cycle with `rst` high loads the lock bits with `cfg_lock_img | ~impl_mask`, where `impl_mask` has ones in bits `NUM_IMPL-1..0`. The same reset clears the protect-enable bit, the select register, the pending flag, `bus_rdata`, `mod_ok` and `erase_go`.
- R2: A write to address 0 stores `bus_wdata[15:0]` into the lock bits when the enable bit is 1 and writes are not frozen. Bits at or above `NUM_IMPL` always read 1.
- R3: While the protect-enable bit (address 1, bit 0, read/write, never frozen) is 0, a write to address 0 leaves the lock bits unchanged.
- R4: An `ilk_strobe` cycle sets the pending flag from the next cycle on. The flag is cleared at the end of a cycle in which `op_done` is high after having been low in the previous cycle, unless a strobe arrives in that same cycle. Lock writes made while the flag is set are ignored.
- R5: A lock write made in a cycle with `hv_suspend` high is ignored.
- R6: `mod_ok` is registered. After each clock edge it equals `~lock & ~prim_lock`, using the lock value and the `prim_lock` input from before that edge.
- R7: A write to address 2 is never gated. It stores bits 15..0 as the low-space select bits and bits 17..16 as the mid-space select bits. Bits 31..18 read 0.
- R8: `erase_go` is registered. It equals `sel_low & ~lock & ~prim_lock` when `erase_req` is high, and 0 otherwise, with the same timing as `mod_ok`.
- R9: After each edge, `bus_rdata` shows the register at `bus_addr` as it was before that edge: address 0 gives the lock bits, address 1 the enable bit, address 2 the select register. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lock_img | input | 16 | Nonvolatile lock image loaded at reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| prim_lock | input | 16 | Primary lock vector |
| ilk_strobe | input | 1 | Interlock write accepted by the controller |
| op_done | input | 1 | Operation-done flag |
| hv_suspend | input | 1 | High-voltage operation suspended |
| erase_req | input | 1 | Erase request from the controller |
| mod_ok | output | 16 | Registered per-sector modify permission |
| erase_go | output | 16 | Registered per-sector erase enable |

## Verification
The assertions assume that `op_done` and `hv_suspend` are plain levels sampled on `clk`, and that `cfg_lock_img` is held steady around a reset. They also treat `ilk_strobe` as arriving at any time, including in the same cycle as a lock write or a rising `op_done`. The stimulus changes inputs only on the falling clock edge and changes the image only between resets. It keeps strobes rare enough that freeze windows both open and close many times. Suspend and the enable bit are toggled independently, so every combination of the three write gates occurs.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOCK = 2'd0,
    REG_CTRL = 2'd1,
    REG_SEL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] impl_mask(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wp_lock_bank.sv
module wp_lock_bank #(
  parameter int NSEC     = 16,
  parameter int NUM_IMPL = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEC-1:0] img,
  input  logic            wr_lock,
  input  logic [NSEC-1:0] wdata,
  input  logic            sle,
  input  logic            freeze,
  output logic [NSEC-1:0] lock_q
);
  logic accept;
  assign accept = wr_lock & sle & ~freeze;

  for (genvar i = 0; i < NSEC; i++) begin : g_bit
    if (i < NUM_IMPL) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst)         q <= img[i];
        else if (accept) q <= wdata[i];
      end
      assign lock_q[i] = q;
    end else begin : g_absent
      assign lock_q[i] = 1'b1;
    end
  end

  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !sle |=> $stable(lock_q));
  a_r5_hold_while_suspend: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(lock_q));
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctrl,
  input  logic wbit,
  input  logic ilk_strobe,
  input  logic op_done,
  input  logic hv_suspend,
  output logic sle,
  output logic freeze
);
  logic ilk_pend, done_q, done_rise;
  assign done_rise = op_done & ~done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sle      <= 1'b0;
      ilk_pend <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= op_done;
      if (wr_ctrl) sle <= wbit;
      if (ilk_strobe)     ilk_pend <= 1'b1;
      else if (done_rise) ilk_pend <= 1'b0;
    end
  end

  assign freeze = ilk_pend | hv_suspend;

  a_r4_pend_set: assert property (@(posedge clk) disable iff (rst)
    ilk_strobe |=> ilk_pend);
  a_r4_pend_clear: assert property (@(posedge clk) disable iff (rst)
    (op_done && !done_q && !ilk_strobe) |=> !ilk_pend);
endmodule

// File: rtl/wp_sel_reg.sv
module wp_sel_reg #(
  parameter int SEL_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (wr_sel) sel_q <= wdata;
  end

  a_r7_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(sel_q));
endmodule

// File: rtl/flash_wp_reg.sv
module flash_wp_reg
  import wp_pkg::*;
#(
  parameter int NSEC     = 16,
  parameter int MID_W    = 2,
  parameter int NUM_IMPL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSEC-1:0]   cfg_lock_img,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSEC-1:0]   prim_lock,
  input  logic              ilk_strobe,
  input  logic              op_done,
  input  logic              hv_suspend,
  input  logic              erase_req,
  output logic [NSEC-1:0]   mod_ok,
  output logic [NSEC-1:0]   erase_go
);
  localparam int SEL_W = NSEC + MID_W;

  reg_sel_e        addr_e;
  logic            wr_lock, wr_ctrl, wr_sel;
  logic            sle, freeze;
  logic [NSEC-1:0] lock_q, permit;
  logic [SEL_W-1:0] sel_q;
  logic            unused_wdata;

  assign addr_e  = reg_sel_e'(bus_addr);
  assign wr_lock = bus_wr & (addr_e == REG_LOCK);
  assign wr_ctrl = bus_wr & (addr_e == REG_CTRL);
  assign wr_sel  = bus_wr & (addr_e == REG_SEL);
  assign unused_wdata = ^bus_wdata;

  wp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wbit(bus_wdata[0]),
    .ilk_strobe(ilk_strobe), .op_done(op_done), .hv_suspend(hv_suspend),
    .sle(sle), .freeze(freeze)
  );

  wp_lock_bank #(.NSEC(NSEC), .NUM_IMPL(NUM_IMPL)) u_lock (
    .clk(clk), .rst(rst), .img(cfg_lock_img), .wr_lock(wr_lock),
    .wdata(bus_wdata[NSEC-1:0]), .sle(sle), .freeze(freeze), .lock_q(lock_q)
  );

  wp_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .wr_sel(wr_sel),
    .wdata(bus_wdata[SEL_W-1:0]), .sel_q(sel_q)
  );

  assign permit = ~lock_q & ~prim_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_ok    <= '0;
      erase_go  <= '0;
      bus_rdata <= '0;
    end else begin
      mod_ok   <= permit;
      erase_go <= erase_req ? (sel_q[NSEC-1:0] & permit) : '0;
      case (addr_e)
        REG_LOCK: bus_rdata <= DATA_W'(lock_q);
        REG_CTRL: bus_rdata <= DATA_W'(sle);
        REG_SEL:  bus_rdata <= DATA_W'(sel_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  a_r6_no_permit_if_locked: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mod_ok & $past(lock_q | prim_lock)) == '0));
  a_r8_erase_needs_permit: assert property (@(posedge clk) disable iff (rst)
    (erase_go & ~mod_ok) == '0);
  a_r8_no_erase_without_req: assert property (@(posedge clk) disable iff (rst)
    !erase_req |=> (erase_go == '0));
endmodule

// File: tb/flash_wp_reg_bench.sv
`timescale 1ns/1ps
module flash_wp_reg_bench;
  localparam int NIMPL = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_lock_img;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] prim_lock;
  logic        ilk_strobe, op_done, hv_suspend, erase_req;
  logic [15:0] mod_ok, erase_go;

  always #2 clk = ~clk;

  flash_wp_reg #(.NSEC(16), .MID_W(2), .NUM_IMPL(NIMPL)) u_flash_wp_reg (
    .clk(clk), .rst(rst), .cfg_lock_img(cfg_lock_img), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prim_lock(prim_lock), .ilk_strobe(ilk_strobe), .op_done(op_done),
    .hv_suspend(hv_suspend), .erase_req(erase_req), .mod_ok(mod_ok),
    .erase_go(erase_go)
  );

  int    nvec = 0, nbad = 0;
  bit    ended = 0;
  string tag = "R1";

  logic [15:0] m_lock;
  logic        m_en, m_pend, m_dq;
  logic [17:0] m_sel;

  function automatic logic [15:0] absent_ones();
    logic [15:0] v = '0;
    for (int i = NIMPL; i < 16; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {16'h0, m_lock};
      2'd1: return {31'h0, m_en};
      2'd2: return {14'h0, m_sel};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string t, input logic [31:0] act, exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic step(input logic r, w, input logic [1:0] a, input logic [31:0] d,
                      input logic stb, dn, sp, er, input logic [15:0] pl);
    logic [31:0] e_rd;
    logic [15:0] e_ok, e_go;
    @(negedge clk);
    rst = r; bus_wr = w; bus_addr = a; bus_wdata = d;
    ilk_strobe = stb; op_done = dn; hv_suspend = sp; erase_req = er; prim_lock = pl;
    if (r) begin
      e_rd = '0; e_ok = '0; e_go = '0;
      m_lock = cfg_lock_img | absent_ones();
      m_en = 0; m_pend = 0; m_dq = 0; m_sel = '0;
    end else begin
      e_rd = model_read(a);
      e_ok = ~m_lock & ~pl;
      e_go = er ? (m_sel[15:0] & e_ok) : 16'h0;
      if (w && a == 2'd0 && m_en && !m_pend && !sp) m_lock = d[15:0] | absent_ones();
      if (w && a == 2'd1) m_en = d[0];
      if (w && a == 2'd2) m_sel = d[17:0];
      if (stb) m_pend = 1;
      else if (dn && !m_dq) m_pend = 0;
      m_dq = dn;
    end
    @(posedge clk); #1;
    check({tag, " rdata"}, bus_rdata, e_rd);
    check("R6 mod_ok", {16'h0, mod_ok}, {16'h0, e_ok});
    check("R8 erase_go", {16'h0, erase_go}, {16'h0, e_go});
  endtask

  task automatic idle(input logic [1:0] a);
    step(0, 0, a, 0, 0, 0, 0, 0, 16'h0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(0, 1, a, d, 0, 0, 0, 0, 16'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!ended) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: erased image then blank image
    cfg_lock_img = 16'hFFFF;
    tag = "R1";
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0); idle(1); idle(2);
    cfg_lock_img = 16'h0000;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0);                                  // reads 0xFFC0
    // R3: enable low, write ignored
    tag = "R3";
    wr(0, 32'h0000_002A); idle(0);
    // R2: enable, write, absent bits stay 1
    tag = "R2";
    wr(1, 32'h1); wr(0, 32'h0000_0015); idle(0);
    wr(0, 32'h0000_0000); idle(0);
    // R4: strobe freezes, done rise releases
    tag = "R4";
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    wr(0, 32'h0000_003F); idle(0);
    step(0, 1, 0, 32'h3F, 0, 1, 0, 0, 0);     // done rises, still frozen
    step(0, 1, 0, 32'h3F, 0, 1, 0, 0, 0);     // released now
    idle(0);
    // R5: suspend blocks a write
    tag = "R5";
    step(0, 1, 0, 32'h0, 0, 0, 1, 0, 0); idle(0);
    // R7: select register with reserved bits
    tag = "R7";
    wr(2, 32'hFFFF_FFFF); idle(2);
    wr(0, 32'h0000_0000);
    step(0, 0, 2, 0, 0, 0, 0, 1, 16'h0005);   // R8 gated erase
    // R9: unmapped address
    tag = "R9";
    wr(3, 32'hFFFF_FFFF); idle(3);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 300) == 0) cfg_lock_img = 16'($urandom);
      step(($urandom % 400) == 0, ($urandom % 2) == 0, 2'($urandom), d,
           ($urandom % 20) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
           ($urandom % 2) == 0, 16'($urandom & $urandom));
    end
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule